// File: doc/BRIEF.md
# Coprocessor Operand Bus Transfer Controller

This block moves a memory operand between system memory and a coprocessor that shares its host processor's bus. The coprocessor watches the host's bus. When the host runs the single memory cycle that belongs to a coprocessor instruction, a strobe marks that cycle. The controller samples the address and data buses at that strobe, together with the direction of the transfer and the operand length in 16-bit words. The host then moves on to its next instruction. The rest of the transfer runs alongside the host.

For a load, the word the host read goes straight into the operand buffer at index 0. If the operand is longer than one word, the controller asks for the bus, waits for grant and reads the remaining words itself. These reads start two bytes above the snooped address and go up by two each time. For a store, the host's read data is not used and only its address is kept. The controller then takes the bus and writes every operand word, taken from the buffer, to consecutive word addresses. A busy flag covers the whole transfer.

Top module: `opx_xfer_ctrl`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `bus_req_o`, `m_rd_o`, `m_wr_o` and `buf_we_o` are all 0.
- R2: A host strobe seen while idle with `op_wr_i`=0 captures `snoop_data_i`. One cycle later the block writes that word to buffer index 0.
- R3: A one-word load finishes after that buffer write and never raises `bus_req_o`.
- R4: For a multi-word operand, `bus_req_o` rises first. No master read or write strobe appears before `bus_gnt_i` has been sampled high. The request stays high through the last master cycle and is low once the transfer ends.
- R5: A load of N words reads word i (1 ≤ i < N) from `snoop_addr_i`+2i and writes it to buffer index i, in ascending order of i.
- R6: A store (`op_wr_i`=1) of N words ignores `snoop_data_i`. It writes buffer word i to `snoop_addr_i`+2i for i = 0..N-1, in order, and makes no buffer write.
- R7: An operand length of 0 is treated as 1 word. A length above MAX_WORDS (default 5) is treated as MAX_WORDS.
- R8: A host strobe that arrives while `busy_o` is high has no effect.
- R9: `busy_o` rises in the cycle after capture and stays high until the final word has moved. Buffer writes and master strobes occur only while `busy_o` is high.
- R10: A master cycle holds its command and address until `m_ack_i` is sampled high. Exactly one of read or write is driven at a time. The next cycle's address is 2 above the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_cyc_i | input | 1 | Marks the host-driven operand bus cycle |
| op_wr_i | input | 1 | 1 = store operand to memory, 0 = load |
| op_words_i | input | 3 | Operand length in 16-bit words |
| snoop_addr_i | input | 20 | Address bus sampled at the host strobe |
| snoop_data_i | input | 16 | Data bus sampled at the host strobe |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| m_addr_o | output | 20 | Master-mode address |
| m_wdata_o | output | 16 | Master-mode write data |
| m_rd_o | output | 1 | Master read command |
| m_wr_o | output | 1 | Master write command |
| m_rdata_i | input | 16 | Master read data, valid with ack |
| m_ack_i | input | 1 | Ends the current master cycle |
| buf_we_o | output | 1 | Operand buffer write enable |
| buf_widx_o | output | 3 | Operand buffer write index |
| buf_wdata_o | output | 16 | Operand buffer write data |
| buf_ridx_o | output | 3 | Operand buffer read index for stores |
| buf_rdata_i | input | 16 | Operand buffer read data |
| busy_o | output | 1 | Transfer in progress |

## Verification
The embedded properties check the bus protocol on every cycle. They cover the grant-before-strobe rule, holding each command and address until acknowledge, the 2-byte address step between back-to-back master cycles, the ban on mixed read and write, and buffer writes only while busy. Only the bench scenarios can show end-to-end data correctness. That includes which word lands at which buffer index and which buffer word reaches which address. They also show that a store discards the host data, that the length clamps apply, that a one-word load never requests the bus, and that a strobe arriving during a long stalled grant is dropped.

// File: rtl/opx_pkg.sv
package opx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } opx_state_e;

endpackage

// File: rtl/opx_len_clamp.sv
module opx_len_clamp #(
    parameter int MAX_WORDS = 5,
    parameter int LEN_W     = $clog2(MAX_WORDS + 1)
) (
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_WORDS);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(1);

    always_comb begin
        if (len_i == '0)          len_o = LEN_MIN;
        else if (len_i > LEN_MAX) len_o = LEN_MAX;
        else                      len_o = len_i;
    end
endmodule

// File: rtl/opx_addr_step.sv
module opx_addr_step #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int STEP = DATA_W / 8;

    assign addr_o = addr_i + ADDR_W'(STEP);
endmodule

// File: rtl/opx_master_drive.sv
module opx_master_drive #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  opx_pkg::opx_state_e st_i,
    input  logic                is_wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic                req_o,
    output logic                rd_o,
    output logic                wr_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W-1:0]   wdata_o
);
    import opx_pkg::*;

    logic in_xfer;

    always_comb begin
        in_xfer = (st_i == ST_XFER);
        req_o   = (st_i == ST_REQ) || in_xfer;
        rd_o    = in_xfer && !is_wr_i;
        wr_o    = in_xfer && is_wr_i;
        addr_o  = in_xfer ? addr_i : '0;
        wdata_o = (in_xfer && is_wr_i) ? wdata_i : '0;
    end
endmodule

// File: rtl/opx_xfer_ctrl.sv
module opx_xfer_ctrl #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 16,
    parameter int MAX_WORDS = 5,
    parameter int LEN_W     = $clog2(MAX_WORDS + 1),
    parameter int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_cyc_i,
    input  logic              op_wr_i,
    input  logic [LEN_W-1:0]  op_words_i,
    input  logic [ADDR_W-1:0] snoop_addr_i,
    input  logic [DATA_W-1:0] snoop_data_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [ADDR_W-1:0] m_addr_o,
    output logic [DATA_W-1:0] m_wdata_o,
    output logic              m_rd_o,
    output logic              m_wr_o,
    input  logic [DATA_W-1:0] m_rdata_i,
    input  logic              m_ack_i,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_widx_o,
    output logic [DATA_W-1:0] buf_wdata_o,
    output logic [IDX_W-1:0]  buf_ridx_o,
    input  logic [DATA_W-1:0] buf_rdata_i,
    output logic              busy_o
);
    import opx_pkg::*;

    localparam int STEP = DATA_W / 8;

    typedef struct packed {
        opx_state_e        st;
        logic              is_wr;
        logic [IDX_W-1:0]  last_idx;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              buf_we;
        logic [IDX_W-1:0]  buf_idx;
        logic [DATA_W-1:0] buf_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [LEN_W-1:0]  eff_len;
    logic [ADDR_W-1:0] snoop_next;
    logic [ADDR_W-1:0] addr_next;

    opx_len_clamp #(.MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W)) u_clamp (
        .len_i (op_words_i),
        .len_o (eff_len)
    );

    opx_addr_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step_snoop (
        .addr_i (snoop_addr_i),
        .addr_o (snoop_next)
    );

    opx_addr_step #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_step_run (
        .addr_i (r_q.addr),
        .addr_o (addr_next)
    );

    opx_master_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .st_i    (r_q.st),
        .is_wr_i (r_q.is_wr),
        .addr_i  (r_q.addr),
        .wdata_i (buf_rdata_i),
        .req_o   (bus_req_o),
        .rd_o    (m_rd_o),
        .wr_o    (m_wr_o),
        .addr_o  (m_addr_o),
        .wdata_o (m_wdata_o)
    );

    // Next-state logic
    always_comb begin
        r_d        = r_q;
        r_d.buf_we = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (host_cyc_i) begin
                    r_d.is_wr    = op_wr_i;
                    r_d.last_idx = IDX_W'(eff_len - LEN_W'(1));
                    if (op_wr_i) begin
                        // store: host data is discarded, only the address kept
                        r_d.idx  = '0;
                        r_d.addr = snoop_addr_i;
                        r_d.st   = ST_REQ;
                    end else begin
                        r_d.buf_we   = 1'b1;
                        r_d.buf_idx  = '0;
                        r_d.buf_data = snoop_data_i;
                        if (eff_len == LEN_W'(1)) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.idx  = IDX_W'(1);
                            r_d.addr = snoop_next;
                            r_d.st   = ST_REQ;
                        end
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt_i) r_d.st = ST_XFER;
            end
            ST_XFER: begin
                if (m_ack_i) begin
                    if (!r_q.is_wr) begin
                        r_d.buf_we   = 1'b1;
                        r_d.buf_idx  = r_q.idx;
                        r_d.buf_data = m_rdata_i;
                    end
                    if (r_q.idx == r_q.last_idx) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.idx  = r_q.idx + IDX_W'(1);
                        r_d.addr = addr_next;
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, is_wr: 1'b0, last_idx: '0, idx: '0,
                     addr: '0, buf_we: 1'b0, buf_idx: '0, buf_data: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign buf_we_o    = r_q.buf_we;
    assign buf_widx_o  = r_q.buf_idx;
    assign buf_wdata_o = r_q.buf_data;
    assign buf_ridx_o  = r_q.idx;

    // R4: no master strobe unless grant was seen on the previous edge
    assert_strobe_after_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(m_rd_o || m_wr_o) |-> $past(bus_gnt_i));

    // R4: master strobes only under an active request
    assert_strobe_under_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_rd_o || m_wr_o) |-> bus_req_o);

    // R10: command and address held until acknowledged
    assert_hold_until_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((m_rd_o || m_wr_o) && !m_ack_i) |=> ((m_rd_o || m_wr_o) && $stable(m_addr_o)));

    // R10: never read and write together
    assert_single_cmd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(m_rd_o && m_wr_o));

    // R10: back-to-back cycles advance by one word
    assert_addr_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((m_rd_o || m_wr_o) && $past(m_rd_o || m_wr_o) && $past(m_ack_i))
        |-> (m_addr_o == $past(m_addr_o) + ADDR_W'(STEP)));

    // R9: buffer writes and master strobes only while busy
    assert_activity_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (buf_we_o || m_rd_o || m_wr_o) |-> busy_o);

    // R6: a store cycle never coincides with a buffer write
    assert_store_no_bufwe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_wr_o |-> !buf_we_o);

    // R7: stored length never exceeds the buffer
    assert_len_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (r_q.last_idx < IDX_W'(MAX_WORDS)));

    // R4: request dropped once the transfer has finished
    assert_req_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> !bus_req_o);
endmodule

// File: tb/tb_opx_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_opx_xfer_ctrl;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int MAXW   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_cyc = 1'b0;
    logic              op_wr = 1'b0;
    logic [2:0]        op_words = 3'd1;
    logic [ADDR_W-1:0] snoop_addr = '0;
    logic [DATA_W-1:0] snoop_data = '0;
    logic              bus_req, bus_gnt;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata, m_rdata;
    logic              m_rd, m_wr, m_ack;
    logic              buf_we;
    logic [2:0]        buf_widx, buf_ridx;
    logic [DATA_W-1:0] buf_wdata, buf_rdata;
    logic              busy;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic gnt_en = 1'b1;
    logic req_seen, nogrant_seen;

    logic [18:0] exp_buf[$];
    logic [35:0] exp_wr[$];
    logic [35:0] act_wr[$];

    always #4 clk = ~clk;

    opx_xfer_ctrl dut (
        .clk_i(clk), .rst_ni(rst_n), .host_cyc_i(host_cyc), .op_wr_i(op_wr),
        .op_words_i(op_words), .snoop_addr_i(snoop_addr), .snoop_data_i(snoop_data),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .m_addr_o(m_addr),
        .m_wdata_o(m_wdata), .m_rd_o(m_rd), .m_wr_o(m_wr), .m_rdata_i(m_rdata),
        .m_ack_i(m_ack), .buf_we_o(buf_we), .buf_widx_o(buf_widx),
        .buf_wdata_o(buf_wdata), .buf_ridx_o(buf_ridx), .buf_rdata_i(buf_rdata),
        .busy_o(busy)
    );

    function automatic logic [DATA_W-1:0] mem_val(input logic [ADDR_W-1:0] a);
        return a[15:0] ^ 16'h5A3C ^ {12'h0, a[19:16]};
    endfunction

    function automatic logic [DATA_W-1:0] buf_val(input logic [2:0] i);
        return 16'hC000 | (16'(i) * 16'h0111);
    endfunction

    assign buf_rdata = buf_val(buf_ridx);

    // Bus arbiter and memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            m_ack   <= 1'b0;
            m_rdata <= '0;
        end else begin
            bus_gnt <= bus_req && gnt_en;
            if ((m_rd || m_wr) && !m_ack) begin
                m_ack <= 1'b1;
                if (m_rd) m_rdata <= mem_val(m_addr);
                if (m_wr) act_wr.push_back({m_addr, m_wdata});
            end else begin
                m_ack <= 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: scoreboard comparison
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_req) req_seen = 1'b1;
            if ((m_rd || m_wr) && !bus_gnt) nogrant_seen = 1'b1;
            if (buf_we) begin
                check(busy, "R9", "busy during buffer write", 64'(busy), 64'd1);
                if (exp_buf.size() == 0) begin
                    check(1'b0, "R8", "unexpected buffer write", 64'({buf_widx, buf_wdata}), 64'd0);
                end else begin
                    logic [18:0] e;
                    e = exp_buf.pop_front();
                    check({buf_widx, buf_wdata} == e, "R5", "buffer idx/data",
                          64'({buf_widx, buf_wdata}), 64'(e));
                end
            end
            while (act_wr.size() > 0) begin
                logic [35:0] a;
                a = act_wr.pop_front();
                if (exp_wr.size() == 0) begin
                    check(1'b0, "R6", "unexpected memory write", 64'(a), 64'd0);
                end else begin
                    logic [35:0] e;
                    e = exp_wr.pop_front();
                    check(a == e, "R6", "memory addr/data", 64'(a), 64'(e));
                end
            end
        end
    end

    // Driver: pushes expected items, then runs the host strobe
    task automatic run_op(input bit wr, input logic [2:0] len, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] hd, input int stall, input bit dup);
        int n;
        n = (len == 0) ? 1 : ((len > MAXW) ? MAXW : int'(len));
        if (!wr) begin
            exp_buf.push_back({3'd0, hd});
            for (int i = 1; i < n; i++)
                exp_buf.push_back({3'(i), mem_val(a + ADDR_W'(2 * i))});
        end else begin
            for (int i = 0; i < n; i++)
                exp_wr.push_back({a + ADDR_W'(2 * i), buf_val(3'(i))});
        end
        req_seen = 1'b0;
        nogrant_seen = 1'b0;
        gnt_en = (stall == 0);
        @(negedge clk);
        host_cyc = 1'b1; op_wr = wr; op_words = len; snoop_addr = a; snoop_data = hd;
        @(negedge clk);
        host_cyc = 1'b0; snoop_data = ~hd;
        check(busy == 1'b1, "R9", "busy after capture", 64'(busy), 64'd1);
        for (int k = 0; k < stall; k++) begin
            if (dup && k == 2) begin
                host_cyc = 1'b1; op_wr = ~wr; op_words = 3'd5;
                snoop_addr = a ^ 20'h0F0F0; snoop_data = 16'hDEAD;
            end else begin
                host_cyc = 1'b0;
            end
            @(negedge clk);
        end
        host_cyc = 1'b0;
        if (stall > 0)
            check(bus_req && !m_rd && !m_wr, "R4", "request held, no strobe without grant",
                  64'({bus_req, m_rd, m_wr}), 64'b100);
        gnt_en = 1'b1;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(exp_buf.size() == 0, wr ? "R6" : "R5", "pending buffer items",
              64'(exp_buf.size()), 64'd0);
        check(exp_wr.size() == 0, "R6", "pending memory writes", 64'(exp_wr.size()), 64'd0);
        check(!bus_req && !busy, "R4", "released after transfer", 64'({bus_req, busy}), 64'd0);
        check(!nogrant_seen, "R4", "strobe without grant", 64'(nogrant_seen), 64'd0);
        if (!wr && n == 1)
            check(!req_seen, "R3", "one-word load requested bus", 64'(req_seen), 64'd0);
        exp_buf.delete();
        exp_wr.delete();
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check({busy, bus_req, m_rd, m_wr, buf_we} == 5'b0, "R1", "outputs in reset",
              64'({busy, bus_req, m_rd, m_wr, buf_we}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, bus_req, m_rd, m_wr, buf_we} == 5'b0, "R1", "outputs after reset",
              64'({busy, bus_req, m_rd, m_wr, buf_we}), 64'd0);

        run_op(1'b0, 3'd1, 20'h01230, 16'h1111, 0, 1'b0);   // R2, R3
        run_op(1'b0, 3'd4, 20'h04000, 16'h2222, 0, 1'b0);   // R5
        run_op(1'b0, 3'd5, 20'hFFFFC, 16'h3333, 0, 1'b0);   // R5 wrap
        run_op(1'b1, 3'd3, 20'h08010, 16'h4444, 0, 1'b0);   // R6
        run_op(1'b1, 3'd1, 20'h00100, 16'h5555, 0, 1'b0);   // R6 single word
        run_op(1'b0, 3'd0, 20'h00200, 16'h6666, 0, 1'b0);   // R7 zero length
        run_op(1'b0, 3'd7, 20'h00300, 16'h7777, 0, 1'b0);   // R7 over length
        run_op(1'b1, 3'd6, 20'h00400, 16'h8888, 0, 1'b0);   // R7 store clamp
        run_op(1'b0, 3'd3, 20'h00500, 16'h9999, 12, 1'b1);  // R4 stall, R8 strobe ignored
        run_op(1'b1, 3'd2, 20'h00600, 16'hAAAA, 8, 1'b1);   // R4, R8 on store
        run_op(1'b0, 3'd2, 20'h00700, 16'hBBBB, 0, 1'b0);   // R10 back-to-back

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule